// File: doc/BRIEF.md
# Multiplexed DRAM Address Decoder

This block turns a 20-bit memory address into the selects that open one word line and one column group. The address arrives in two halves over a shared 10-bit bus. An active-low row strobe marks the first half and an active-low column strobe marks the second. Both strobes are sampled on the system clock, and a high-to-low change is treated as a strobe edge.

The first half carries the bank number in its top 3 bits and the low 7 bits of the row. The second half carries the high 3 bits of the row in its top bits and the 7-bit column in its low bits. A global stage decodes the bank into a one-hot select. Eight local stages each decode a 10-bit row into 1024 word-line selects and a 7-bit column into 128 column-group selects. Each local stage is enabled only by its own bank select and by the open phases. The decoder serves a memory of two bits per address, where one open row exposes 128 two-bit words.

Top module: `dram_addr_decoder`

## Requirements
- R1: After reset, bank_sel_o, row_sel_o and col_sel_o are all zero.
- R2: One clock after the row strobe falls, bank_sel_o has only bit addr_i[9:7] set, and row_sel_o and col_sel_o stay zero.
- R3: On the first column strobe fall while the row strobe is low, the row becomes {addr_i[9:7], row-phase addr_i[6:0]} and the column becomes addr_i[6:0]. One clock later, row_sel_o bit bank*1024+row and col_sel_o bit bank*128+col are the only set bits.
- R4: A later column strobe fall within the same row phase updates only the column. Its addr_i[9:7] is ignored, and the word line stays the same.
- R5: When the column strobe goes high, col_sel_o clears on the next clock while row_sel_o holds.
- R6: When the row strobe goes high, all three select outputs clear on the next clock.
- R7: A column strobe fall while the row strobe is high is ignored. A column strobe already low when the row strobe falls opens no column.
- R8: At most one bit of bank_sel_o, of row_sel_o and of col_sel_o is high at any time.
- R9: A row or column select is high only in the slice of the bank whose bank select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 10 | Shared row/column address bus |
| ras_ni | input | 1 | Active-low row strobe |
| cas_ni | input | 1 | Active-low column strobe |
| bank_sel_o | output | 8 | One-hot bank select |
| row_sel_o | output | 8192 | Word-line selects, 1024 per bank, bank-major |
| col_sel_o | output | 1024 | Column-group selects, 128 per bank, bank-major |

## Verification
The assertions assume that addr_i is stable on every clock edge at which a strobe is seen to fall. They also assume that the strobes are synchronous to clk_i and change at most once per clock. The bench changes addr_i and the strobes only on falling clock edges. It holds each strobe level for at least one full rising edge, so every fall is seen exactly once with a settled address.

// File: rtl/dram_addr_pkg.sv
package dram_addr_pkg;
  parameter int ADDR_W   = 10;
  parameter int BANK_W   = 3;
  parameter int ROW_W    = 10;
  parameter int COL_W    = 7;
  localparam int NBANK   = 1 << BANK_W;
  localparam int NROW    = 1 << ROW_W;
  localparam int NCOL    = 1 << COL_W;
  localparam int ROW_LO_W = ADDR_W - BANK_W;
  localparam int ROW_HI_W = ROW_W - ROW_LO_W;
endpackage

// File: rtl/dram_addr_latch.sv
module dram_addr_latch
  import dram_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ras_ni,
  input  logic              cas_ni,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              row_act_o,
  output logic              row_vld_o,
  output logic              col_act_o
);
  logic ras_q, cas_q;
  logic ras_fall, cas_fall;

  assign ras_fall = ras_q & ~ras_ni;
  assign cas_fall = cas_q & ~cas_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      bank_o    <= '0;
      row_o     <= '0;
      col_o     <= '0;
      row_act_o <= 1'b0;
      row_vld_o <= 1'b0;
      col_act_o <= 1'b0;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      if (ras_ni) begin
        row_act_o <= 1'b0;
        row_vld_o <= 1'b0;
        col_act_o <= 1'b0;
      end else begin
        if (ras_fall) begin
          row_act_o             <= 1'b1;
          bank_o                <= addr_i[ADDR_W-1 -: BANK_W];
          row_o[ROW_LO_W-1:0]   <= addr_i[ROW_LO_W-1:0];
        end
        if (cas_fall && row_act_o) begin
          col_act_o <= 1'b1;
          col_o     <= addr_i[COL_W-1:0];
          // row high bits taken from the first column phase only
          if (!row_vld_o) begin
            row_o[ROW_W-1 -: ROW_HI_W] <= addr_i[ADDR_W-1 -: ROW_HI_W];
            row_vld_o                  <= 1'b1;
          end
        end else if (cas_ni) begin
          col_act_o <= 1'b0;
        end
      end
    end
  end

  // R4
  page_row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall && row_vld_o && !ras_ni) |=> $stable(row_o));
  // R7
  cas_needs_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_act_o) |-> $past(row_act_o));
endmodule

// File: rtl/dram_bank_dec.sv
module dram_bank_dec
  import dram_addr_pkg::*;
(
  input  logic              en_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [NBANK-1:0]  sel_o
);
  always_comb begin
    sel_o = '0;
    if (en_i) sel_o[bank_i] = 1'b1;
  end
endmodule

// File: rtl/dram_bank_local.sv
module dram_bank_local
  import dram_addr_pkg::*;
(
  input  logic             bank_sel_i,
  input  logic             row_en_i,
  input  logic             col_en_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [NROW-1:0]  row_sel_o,
  output logic [NCOL-1:0]  col_sel_o
);
  always_comb begin
    row_sel_o = '0;
    col_sel_o = '0;
    if (bank_sel_i && row_en_i) row_sel_o[row_i] = 1'b1;
    if (bank_sel_i && col_en_i) col_sel_o[col_i] = 1'b1;
  end
endmodule

// File: rtl/dram_addr_decoder.sv
module dram_addr_decoder
  import dram_addr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  output logic [NBANK-1:0]      bank_sel_o,
  output logic [NBANK*NROW-1:0] row_sel_o,
  output logic [NBANK*NCOL-1:0] col_sel_o
);
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic row_act, row_vld, col_act;

  dram_addr_latch u_latch (
    .clk_i, .rst_ni, .addr_i, .ras_ni, .cas_ni,
    .bank_o(bank), .row_o(row), .col_o(col),
    .row_act_o(row_act), .row_vld_o(row_vld), .col_act_o(col_act)
  );

  dram_bank_dec u_bank_dec (.en_i(row_act), .bank_i(bank), .sel_o(bank_sel_o));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dram_bank_local u_local (
      .bank_sel_i(bank_sel_o[b]),
      .row_en_i  (row_vld),
      .col_en_i  (col_act),
      .row_i     (row),
      .col_i     (col),
      .row_sel_o (row_sel_o[b*NROW +: NROW]),
      .col_sel_o (col_sel_o[b*NCOL +: NCOL])
    );
  end

  // R8
  bank_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel_o));
  // R8
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));
  // R8
  col_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_sel_o));
  // R6
  ras_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ras_ni) |-> (row_sel_o == '0 && col_sel_o == '0 && bank_sel_o == '0));
  // R9
  col_has_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o != '0) |-> (row_sel_o != '0 && bank_sel_o != '0));
endmodule

// File: tb/dram_addr_decoder_tb_top.sv
module dram_addr_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic ras_n = 1'b1, cas_n = 1'b1;
  logic [7:0]    bank_sel;
  logic [8191:0] row_sel;
  logic [1023:0] col_sel;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  dram_addr_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ras_ni(ras_n), .cas_ni(cas_n),
    .bank_sel_o(bank_sel), .row_sel_o(row_sel), .col_sel_o(col_sel)
  );

  function automatic int idx_row();
    int r = -1;
    for (int i = 0; i < 8192; i++) if (row_sel[i]) r = i;
    return r;
  endfunction
  function automatic int idx_col();
    int r = -1;
    for (int i = 0; i < 1024; i++) if (col_sel[i]) r = i;
    return r;
  endfunction
  function automatic int idx_bank();
    int r = -1;
    for (int i = 0; i < 8; i++) if (bank_sel[i]) r = i;
    return r;
  endfunction

  // expected index -1 means no bit set
  task automatic chk(string tag, int eb, int er, int ec);
    int ab = idx_bank(), ar = idx_row(), ac = idx_col();
    int nb = $countones(bank_sel), nr = $countones(row_sel), nc = $countones(col_sel);
    n_chk++;
    if (nb > 1 || nr > 1 || nc > 1 || ab != eb || ar != er || ac != ec) begin
      n_err++;
      $display("FAIL %s: bank=%0d(n%0d) row=%0d(n%0d) col=%0d(n%0d) exp bank=%0d row=%0d col=%0d",
               tag, ab, nb, ar, nr, ac, nc, eb, er, ec);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset", -1, -1, -1);
  endtask

  // full access: row phase, column phase, page column, cas close, ras close
  task automatic t_access(int b, int r, int c, int c2);
    int rlo = r & 7'h7f, rhi = r >> 7;
    addr = 10'((b << 7) | rlo); ras_n = 1'b0; step();
    chk("R2 row phase", b, -1, -1);
    addr = 10'((rhi << 7) | c); cas_n = 1'b0; step();
    chk("R3 R8 R9 column phase", b, b*1024 + r, b*128 + c);
    cas_n = 1'b1; step();
    chk("R5 cas close", b, b*1024 + r, -1);
    addr = 10'((((~rhi) & 7) << 7) | c2); cas_n = 1'b0; step();
    chk("R4 page column", b, b*1024 + r, b*128 + c2);
    cas_n = 1'b1; ras_n = 1'b1; step();
    chk("R6 ras close", -1, -1, -1);
  endtask

  task automatic t_ras_drop_with_cas();
    addr = 10'h0c5; ras_n = 1'b0; step();
    addr = 10'h233; cas_n = 1'b0; step();
    ras_n = 1'b1; step();
    chk("R6 ras high with cas low", -1, -1, -1);
    cas_n = 1'b1; step();
  endtask

  task automatic t_cas_without_ras();
    addr = 10'h155; cas_n = 1'b0; step();
    chk("R7 cas alone", -1, -1, -1);
    addr = 10'h3c1; ras_n = 1'b0; step();
    chk("R7 ras after cas held low", 7, -1, -1);
    step();
    chk("R7 no column opened", 7, -1, -1);
    cas_n = 1'b1; ras_n = 1'b1; step();
    chk("R6 close", -1, -1, -1);
  endtask

  initial begin
    fork
      begin
        step(); step();
        t_reset();
        rst_n = 1'b1; step();
        t_reset();
        t_access(5, 10'h1aa, 7'h11, 7'h7f);
        t_access(0, 0, 0, 1);
        t_access(7, 1023, 127, 0);
        t_access(2, 10'h2b5, 7'h40, 7'h3e);
        for (int k = 0; k < 8; k++)
          t_access(k, (k * 131 + 17) & 10'h3ff, (k * 37 + 5) & 7'h7f, (k * 11) & 7'h7f);
        t_ras_drop_with_cas();
        t_cas_without_ras();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule